// File: doc/BRIEF.md
# Four-Channel DMA Mode and Counter Unit

This block keeps the programmable state of four DMA channels and moves their address and count registers forward as transfers finish. Software programs a channel's behaviour through one 8-bit write-only mode port: the two low bits of the written byte pick the channel, and the upper six bits land in that channel's mode register. A separate per-channel load strobe writes a 16-bit address and a 16-bit count into both the base and the current registers at once.

Each transfer acknowledge moves the current address by one, up or down, and lowers the current count by one. An acknowledge that finds the count at zero is the terminal count. At that point the count wraps to all ones and a sticky status bit is raised. The channel then either halts or reloads its current registers from the base copies. For each channel the block also presents the stored transfer mode, transfer type and direction, and the decoded strobe enables.

Top module: `dma4_mode_counter`

## Requirements
- R1: A mode write with `mode_wdata[1:0]` = c stores `mode_wdata[7:2]` into channel c alone. The other three channels keep their values. The stored fields are visible from the next cycle.
- R2: Channel i shows its mode on `xfer_mode[2i+1:2i]`, taken from bits 7:6 (00 demand, 01 single, 10 reserved, 11 cascade). It shows bit 5 on `addr_dec[i]`, bit 4 on `auto_init[i]`, and bits 3:2 on `xfer_type[2i+1:2i]` (00 verify, 01 write, 10 read, 11 invalid). `wr_xfer[i]` is 1 only for type 01 in demand or single mode. `rd_xfer[i]` is 1 only for type 10 in demand or single mode.
- R3: On an accepted acknowledge, the current address rises by one when `addr_dec` is 0 and falls by one when it is 1. The current count falls by one on every accepted acknowledge.
- R4: An accepted acknowledge with current count 0 is a terminal count. The count wraps to 16'hFFFF and `tc_status[i]` is set. A `tc_rd` pulse clears all of `tc_status`, but a terminal count in the same cycle keeps its own bit set.
- R5: At terminal count with `auto_init` = 1, the current address and count are reloaded from the base registers instead of being stepped.
- R6: At terminal count with `auto_init` = 0, the registers step and the channel then ignores acknowledges until its next load.
- R7: A channel in reserved mode, in cascade mode, or with invalid type still stores the written value. Such a channel makes no address or count update on acknowledge and asserts no strobe enable.
- R8: Reset and a `mclr` pulse clear every mode register to 0 (increment, no autoinitialize). They also clear `tc_status` and any halt.
- R9: `ld_we[i]` writes `ld_addr` and `ld_cnt` into channel i's base and current registers. A load takes priority over an acknowledge to the same channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Master clear pulse |
| mode_we | input | 1 | Mode port write strobe |
| mode_wdata | input | 8 | Mode byte: [1:0] channel, [7:2] mode fields |
| ld_we | input | 4 | Per-channel base/current load strobe |
| ld_addr | input | AW | Address value for a load |
| ld_cnt | input | CW | Count value for a load |
| ack | input | 4 | Per-channel transfer acknowledge |
| tc_rd | input | 1 | Read of terminal-count status (clears it) |
| cur_addr | output | 4*AW | Current addresses, channel i at [AW*i +: AW] |
| cur_cnt | output | 4*CW | Current counts, channel i at [CW*i +: CW] |
| xfer_mode | output | 8 | Transfer mode per channel |
| xfer_type | output | 8 | Transfer type per channel |
| addr_dec | output | 4 | Decrement select per channel |
| auto_init | output | 4 | Autoinitialize enable per channel |
| wr_xfer | output | 4 | Write strobe enable (I/O to memory) |
| rd_xfer | output | 4 | Read strobe enable (memory to I/O) |
| tc_status | output | 4 | Sticky terminal-count flags |

## Verification
Two events can land in the same cycle: a terminal count setting a status bit, and a status read clearing it. The bench drives a channel down to count zero and then raises its final acknowledge together with `tc_rd`. It expects that channel's bit to survive while every other bit clears. A second collision, a load and an acknowledge on one channel, is driven in one cycle and judged by the loaded values appearing unstepped.

// File: rtl/dma4_mode_counter.sv
module dma4_mode_counter #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr,
  input  logic            mode_we,
  input  logic [7:0]      mode_wdata,
  input  logic [3:0]      ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [CW-1:0]   ld_cnt,
  input  logic [3:0]      ack,
  input  logic            tc_rd,
  output logic [4*AW-1:0] cur_addr,
  output logic [4*CW-1:0] cur_cnt,
  output logic [7:0]      xfer_mode,
  output logic [7:0]      xfer_type,
  output logic [3:0]      addr_dec,
  output logic [3:0]      auto_init,
  output logic [3:0]      wr_xfer,
  output logic [3:0]      rd_xfer,
  output logic [3:0]      tc_status
);

  logic [3:0] halted;
  logic [3:0] tc_hit;

  for (genvar g = 0; g < 4; g++) begin : g_ch
    logic [5:0]    mode_q;
    logic [AW-1:0] base_a, cur_a;
    logic [CW-1:0] base_c, cur_c;
    logic          ok, step;

    assign ok   = !mode_q[5] && (mode_q[1:0] != 2'b11);
    assign step = ack[g] && !halted[g] && ok;
    assign tc_hit[g] = step && !ld_we[g] && (cur_c == '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                         mode_q <= '0;
      else if (mclr)                                      mode_q <= '0;
      else if (mode_we && mode_wdata[1:0] == 2'(g))       mode_q <= mode_wdata[7:2];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        base_a <= '0; cur_a <= '0; base_c <= '0; cur_c <= '0;
      end else if (ld_we[g]) begin
        base_a <= ld_addr; cur_a <= ld_addr;
        base_c <= ld_cnt;  cur_c <= ld_cnt;
      end else if (tc_hit[g] && mode_q[2]) begin
        cur_a <= base_a; cur_c <= base_c;
      end else if (step) begin
        cur_a <= mode_q[3] ? cur_a - 1'b1 : cur_a + 1'b1;
        cur_c <= cur_c - 1'b1;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                       halted[g] <= 1'b0;
      else if (ld_we[g] || mclr)        halted[g] <= 1'b0;
      else if (tc_hit[g] && !mode_q[2]) halted[g] <= 1'b1;

    assign cur_addr[AW*g +: AW] = cur_a;
    assign cur_cnt[CW*g +: CW]  = cur_c;
    assign xfer_mode[2*g +: 2]  = mode_q[5:4];
    assign addr_dec[g]          = mode_q[3];
    assign auto_init[g]         = mode_q[2];
    assign xfer_type[2*g +: 2]  = mode_q[1:0];
    assign wr_xfer[g]           = !mode_q[5] && (mode_q[1:0] == 2'b01);
    assign rd_xfer[g]           = !mode_q[5] && (mode_q[1:0] == 2'b10);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     tc_status <= '0;
    else if (mclr)  tc_status <= '0;
    else            tc_status <= (tc_status & ~{4{tc_rd}}) | tc_hit;

endmodule

// File: rtl/dma4_mode_counter_chk.sv
module dma4_mode_counter_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mclr,
  input logic            mode_we,
  input logic [7:0]      mode_wdata,
  input logic [3:0]      ld_we,
  input logic [3:0]      ack,
  input logic [4*AW-1:0] cur_addr,
  input logic [4*CW-1:0] cur_cnt,
  input logic [7:0]      xfer_mode,
  input logic [7:0]      xfer_type,
  input logic [3:0]      addr_dec,
  input logic [3:0]      auto_init,
  input logic [3:0]      wr_xfer,
  input logic [3:0]      rd_xfer,
  input logic [3:0]      tc_status,
  input logic [3:0]      halted
);

  assert_mclr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (addr_dec == 4'b0) && (auto_init == 4'b0) && (tc_status == 4'b0));

  for (genvar g = 0; g < 4; g++) begin : g_a
    logic acc, bad;
    assign bad = xfer_mode[2*g+1] || (xfer_type[2*g +: 2] == 2'b11);
    assign acc = ack[g] && !halted[g] && !bad && !ld_we[g];

    assert_mode_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we && !mclr && mode_wdata[1:0] == 2'(g)) |=>
      ({xfer_mode[2*g +: 2], addr_dec[g], auto_init[g], xfer_type[2*g +: 2]} == $past(mode_wdata[7:2])));

    assert_step_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !addr_dec[g] && cur_cnt[CW*g +: CW] != '0) |=>
      (cur_addr[AW*g +: AW] == $past(cur_addr[AW*g +: AW]) + 1'b1));

    assert_step_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && addr_dec[g] && cur_cnt[CW*g +: CW] != '0) |=>
      (cur_addr[AW*g +: AW] == $past(cur_addr[AW*g +: AW]) - 1'b1));

    assert_tc_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !mclr && cur_cnt[CW*g +: CW] == '0) |=> tc_status[g]);

    assert_tc_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !mclr && !auto_init[g] && cur_cnt[CW*g +: CW] == '0) |=> halted[g]);

    assert_ignored_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && bad && !ld_we[g]) |=> $stable(cur_addr[AW*g +: AW]) && $stable(cur_cnt[CW*g +: CW]));

    assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bad |-> !wr_xfer[g] && !rd_xfer[g]);
  end

endmodule

bind dma4_mode_counter dma4_mode_counter_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/dma4_mode_counter_bench.sv
module dma4_mode_counter_bench;
  logic clk = 0, rst_n = 0, mclr = 0, mode_we = 0, tc_rd = 0;
  logic [7:0] mode_wdata = 0;
  logic [3:0] ld_we = 0, ack = 0;
  logic [15:0] ld_addr = 0, ld_cnt = 0;
  logic [63:0] cur_addr, cur_cnt;
  logic [7:0] xfer_mode, xfer_type;
  logic [3:0] addr_dec, auto_init, wr_xfer, rd_xfer, tc_status;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [5:0] model [4];

  always #5 clk = ~clk;

  dma4_mode_counter u_dma4_mode_counter (.*);

  localparam logic [9:0] VEC [8] = '{
    {8'h44, 2'b10}, {8'h49, 2'b01}, {8'h06, 2'b10}, {8'h03, 2'b00},
    {8'hC4, 2'b00}, {8'h89, 2'b00}, {8'h7E, 2'b00}, {8'h2B, 2'b01}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wmode(input logic [7:0] d);
    @(negedge clk); mode_we = 1; mode_wdata = d;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic load(input int c, input logic [15:0] a, input logic [15:0] n, input bit with_ack);
    @(negedge clk); ld_we[c] = 1; ld_addr = a; ld_cnt = n; ack[c] = with_ack;
    @(negedge clk); ld_we = 0; ack = 0;
  endtask

  task automatic pulse(input int c, input bit rd);
    @(negedge clk); ack[c] = 1; tc_rd = rd;
    @(negedge clk); ack = 0; tc_rd = 0;
  endtask

  task automatic state(input string req, input int c, input logic [15:0] a, input logic [15:0] n);
    chk(req, cur_addr[16*c +: 16], a);
    chk(req, cur_cnt[16*c +: 16], n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset modes", {xfer_mode, xfer_type, addr_dec, auto_init}, 0);
    chk("R8 reset counters", {cur_addr, cur_cnt} == 0, 1);
    chk("R8 reset tc", tc_status, 0);
    rst_n = 1;
    for (int c = 0; c < 4; c++) model[c] = 6'b0;

    // R1 R2 table walk
    for (int i = 0; i < 8; i++) begin
      wmode(VEC[i][9:2]);
      model[VEC[i][3:2]] = VEC[i][9:4];
      for (int c = 0; c < 4; c++)
        chk("R1 mode fields", {xfer_mode[2*c +: 2], addr_dec[c], auto_init[c], xfer_type[2*c +: 2]}, model[c]);
      chk("R2 strobes", {wr_xfer[VEC[i][3:2]], rd_xfer[VEC[i][3:2]]}, VEC[i][1:0]);
    end

    // R3 R4 R6 ch0 single write increment, no autoinit
    wmode(8'h44); load(0, 16'h1000, 16'd2, 0);
    state("R9 load", 0, 16'h1000, 16'd2);
    pulse(0, 0); state("R3 inc", 0, 16'h1001, 16'd1);
    pulse(0, 0); state("R3 inc", 0, 16'h1002, 16'd0);
    pulse(0, 0); state("R4 wrap", 0, 16'h1003, 16'hFFFF);
    chk("R4 tc set", tc_status, 4'b0001);
    pulse(0, 0); state("R6 halted ignores ack", 0, 16'h1003, 16'hFFFF);

    // R3 R5 ch1 decrement with autoinit
    wmode(8'h79); load(1, 16'h2000, 16'd1, 0);
    pulse(1, 0); state("R3 dec", 1, 16'h1FFF, 16'd0);
    pulse(1, 0); state("R5 reload", 1, 16'h2000, 16'd1);
    chk("R4 tc set ch1", tc_status, 4'b0011);
    @(negedge clk); tc_rd = 1; @(negedge clk); tc_rd = 0;
    chk("R4 tc read clears", tc_status, 4'b0000);
    pulse(1, 0);
    pulse(1, 1);
    chk("R4 tc set beats read", tc_status, 4'b0010);
    state("R5 reload again", 1, 16'h2000, 16'd1);

    // R7 reserved, invalid, cascade
    wmode(8'h86); load(2, 16'h3000, 16'd5, 0);
    pulse(2, 0); state("R7 reserved no update", 2, 16'h3000, 16'd5);
    chk("R7 reserved no strobe", {wr_xfer[2], rd_xfer[2]}, 0);
    wmode(8'h4F); load(3, 16'h4000, 16'd7, 0);
    pulse(3, 0); state("R7 invalid no update", 3, 16'h4000, 16'd7);
    chk("R7 invalid stored", xfer_type[7:6], 2'b11);
    wmode(8'hC6);
    pulse(2, 0); state("R7 cascade no update", 2, 16'h3000, 16'd5);
    chk("R7 cascade no strobe", {xfer_mode[5:4], wr_xfer[2], rd_xfer[2]}, 4'b1100);

    // R8 master clear
    wmode(8'h79);
    @(negedge clk); mclr = 1; @(negedge clk); mclr = 0;
    chk("R8 mclr dir/auto", {addr_dec, auto_init}, 0);
    chk("R8 mclr modes", {xfer_mode, xfer_type}, 0);
    chk("R8 mclr tc", tc_status, 0);

    // R9 load beats ack
    load(0, 16'h5000, 16'd3, 1);
    state("R9 load wins", 0, 16'h5000, 16'd3);
    pulse(0, 0); state("R9 after load step", 0, 16'h5001, 16'd2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule